// File: doc/BRIEF.md
# Display-Side Link Deserializer with Strobe Synthesis

This block sits at the display end of a two-chip serial display link. It receives frames bit by bit from the host-side serializer and decodes each one as a parallel write, a read request, or a serial-peripheral write. It then drives the display's parallel port. There are no strobe wires on the link, so the block builds every display strobe itself. Each low pulse has a width counted in cycles of the fast internal clock, and that width depends on the kind of transaction.

For a write, the data, control and read/write lines are set up first. One of two write clocks then pulses low, chosen by the frame's target-select bit. For a read, the block drives the control lines, releases the data bus and pulls the selected write clock low long enough for the display to answer. It samples the bus on the rising edge it makes itself and returns the 18 data bits to the host on the same link. In serial-peripheral mode, the chip-select bit drives write clock 0 as a level, and the data bit appears on two output pins. The serial clock is replayed as a low pulse on two other pins.

Top module: `disp_link_slave`

## Requirements
- R1: A frame begins with a marker bit sampled on a rising `clk` edge where `rx_en` is high. Marker 1 is followed by 26 payload bits: data[0..17] LSB first, then ctl[0..5], then rw, then sel. Marker 0 is followed by 8 payload bits: ctl[0..5], rw, sel. Payload bits are sampled only on cycles with `rx_en` high.
- R2: A long frame is a write. `dp_out` takes the data, `ctl_out` and `rw_out` take their fields, and `dp_oe` is 1. Write clock `wclk0` (sel=0) then goes low for exactly LOW_W0=15 cycles, or `wclk1` (sel=1) for exactly LOW_W1=6 cycles. The other write clock stays high.
- R3: `dp_out`, `ctl_out` and `rw_out` take their new values at least SETUP_CYC=2 cycles before the strobe falls. They stay unchanged while it is low.
- R4: A short frame with rw=1 is a read. `ctl_out` and `rw_out`=1 are driven, `dp_oe` goes to 0, and the selected write clock goes low for exactly LOW_RD=56 cycles.
- R5: A read samples `dp_in` at the clock edge where the strobe rises. `tx_en` then stays high for 27 consecutive cycles, with `tx_bit` carrying in turn: a 1 marker, data bits 0..17, and 8 zeros. After that, `tx_en` returns low.
- R6: With `spi_mode`=1, a short frame with rw=0 is a serial-peripheral write. ctl[5] is driven onto `wclk0` as a chip-select level. ctl[4] appears on `dp_out[7]` and `ctl_out[4]`, and ctl[3:0] appear on `ctl_out[3:0]`. `dp_out[6]` and `ctl_out[5]` go low together for exactly LOW_SPI=12 cycles and then return high. `wclk1` stays high.
- R7: A short frame with rw=0 while `spi_mode`=0 has no effect on any output.
- R8: A frame whose last bit is sampled while a transaction is still running is discarded. A frame whose last bit is sampled on the same edge where a write strobe rises is accepted.
- R9: After reset, `wclk0` and `wclk1` are high, `dp_out`, `ctl_out` and `rw_out` are 0, `dp_oe` is 1 and `tx_en` is 0.
- R10: `wclk0` and `wclk1` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_mode | input | 1 | 1 selects serial-peripheral handling of short write frames |
| rx_bit | input | 1 | Received serial bit |
| rx_en | input | 1 | Qualifies `rx_bit` in this cycle |
| dp_in | input | 18 | Data bus value driven by the display during reads |
| dp_out | output | 18 | Data bus value driven toward the display |
| dp_oe | output | 1 | Data bus output enable (0 while reading) |
| ctl_out | output | 6 | Control lines toward the display |
| rw_out | output | 1 | Read/write line toward the display |
| wclk0 | output | 1 | Write clock 0 (active-low pulse, or chip-select level in SPI mode) |
| wclk1 | output | 1 | Write clock 1 (active-low pulse) |
| tx_bit | output | 1 | Returned serial bit |
| tx_en | output | 1 | High while the return frame is sent |

## Verification
Two events can coincide: a frame from the link can finish on the same edge where a write strobe ends and the engine returns to idle. The bench launches a short read frame right behind a long write frame. It sets the gap so that the read frame's last bit lands exactly on the strobe's rising edge in one run, and one cycle earlier in another run. In the first run it expects a full read pulse and a correct return frame. In the second run it expects no further strobe and the data bus still driven.

// File: rtl/dls_pkg.sv
package dls_pkg;
  parameter int DATA_W = 18;
  parameter int CTL_W  = 6;
  localparam int PAY_LONG  = DATA_W + CTL_W + 2;
  localparam int PAY_SHORT = CTL_W + 2;
  localparam int RET_LEN   = 1 + PAY_LONG;

  // pin positions that the display decodes in serial-peripheral mode
  localparam int SPI_DP_DAT = 7;
  localparam int SPI_DP_CLK = 6;
  localparam int SPI_CT_DAT = 4;
  localparam int SPI_CT_CLK = 5;
  localparam int SPI_CT_CS  = 5;

  typedef enum logic [1:0] {K_NONE, K_WRITE, K_READ, K_SPI} kind_e;

  typedef struct packed {
    logic              lng;
    logic              sel;
    logic              rw;
    logic [CTL_W-1:0]  ctl;
    logic [DATA_W-1:0] data;
  } frame_t;

  function automatic kind_e classify(input logic lng, input logic rw, input logic spi);
    if (lng)      return K_WRITE;
    else if (rw)  return K_READ;
    else if (spi) return K_SPI;
    else          return K_NONE;
  endfunction

  function automatic int unsigned low_cycles(input kind_e k, input logic sel,
      input int unsigned w0, input int unsigned w1,
      input int unsigned wrd, input int unsigned wspi);
    case (k)
      K_READ:  return wrd;
      K_SPI:   return wspi;
      default: return sel ? w1 : w0;
    endcase
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
      input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/dls_frame_rx.sv
module dls_frame_rx
  import dls_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rx_bit,
  input  logic   rx_en,
  output logic   frame_vld,
  output frame_t frame
);
  localparam int CNTW = $clog2(PAY_LONG + 1);

  logic                busy_q, lng_q;
  logic [CNTW-1:0]     idx_q, last_idx, pos;
  logic [PAY_LONG-1:0] sh_q, sh_nx;
  logic                done_w;

  assign last_idx = lng_q ? CNTW'(PAY_LONG - 1) : CNTW'(PAY_SHORT - 1);
  // short frames land in the upper (control) part of the shift image
  assign pos      = idx_q + (lng_q ? '0 : CNTW'(DATA_W));
  assign done_w   = rx_en && busy_q && (idx_q == last_idx);

  always_comb begin
    sh_nx = sh_q;
    if (busy_q) sh_nx[pos] = rx_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      lng_q     <= 1'b0;
      idx_q     <= '0;
      sh_q      <= '0;
      frame_vld <= 1'b0;
      frame     <= '0;
    end else begin
      frame_vld <= 1'b0;
      if (rx_en) begin
        if (!busy_q) begin
          busy_q <= 1'b1;
          lng_q  <= rx_bit;
          idx_q  <= '0;
        end else begin
          sh_q <= sh_nx;
          if (done_w) begin
            busy_q     <= 1'b0;
            frame_vld  <= 1'b1;
            frame.lng  <= lng_q;
            frame.data <= sh_nx[DATA_W-1:0];
            frame.ctl  <= sh_nx[DATA_W +: CTL_W];
            frame.rw   <= sh_nx[DATA_W + CTL_W];
            frame.sel  <= sh_nx[DATA_W + CTL_W + 1];
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      end
    end
  end

  // R1: a decoded frame only follows a qualified bit
  p_frame_after_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |-> $past(rx_en));
endmodule

// File: rtl/dls_down_timer.sv
module dls_down_timer #(
  parameter  int MAXV = 56,
  localparam int TW   = $clog2(MAXV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R2: a requested width never exceeds the counter's range
  p_load_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val <= TW'(MAXV)));
endmodule

// File: rtl/dls_ret_tx.sv
module dls_ret_tx
  import dls_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  output logic              tx_bit,
  output logic              tx_en,
  output logic              last
);
  localparam int CW = $clog2(RET_LEN + 1);

  logic [RET_LEN-1:0] sh_q;
  logic [CW-1:0]      cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      tx_en <= 1'b0;
    end else if (start) begin
      sh_q  <= {{PAY_SHORT{1'b0}}, data, 1'b1};
      cnt_q <= CW'(RET_LEN);
      tx_en <= 1'b1;
    end else if (tx_en) begin
      sh_q  <= sh_q >> 1;
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) tx_en <= 1'b0;
    end
  end

  assign tx_bit = tx_en & sh_q[0];
  assign last   = tx_en && (cnt_q == CW'(1));

  // R5: every return frame opens with the marker
  p_marker_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> tx_bit);
  // R5: control positions of the return frame are zeros
  p_tail_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && cnt_q <= CW'(PAY_SHORT)) |-> !tx_bit);
endmodule

// File: rtl/disp_link_slave.sv
module disp_link_slave
  import dls_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int LOW_W0    = 15,
  parameter int LOW_W1    = 6,
  parameter int LOW_RD    = 56,
  parameter int LOW_SPI   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_mode,
  input  logic              rx_bit,
  input  logic              rx_en,
  input  logic [DATA_W-1:0] dp_in,
  output logic [DATA_W-1:0] dp_out,
  output logic              dp_oe,
  output logic [CTL_W-1:0]  ctl_out,
  output logic              rw_out,
  output logic              wclk0,
  output logic              wclk1,
  output logic              tx_bit,
  output logic              tx_en
);
  localparam int MAXW = int'(max4(LOW_W0, LOW_W1, LOW_RD, max4(LOW_SPI, SETUP_CYC, 1, 1)));
  localparam int TW   = $clog2(MAXW + 1);

  typedef enum logic [1:0] {E_IDLE, E_SETUP, E_LOW, E_TX} eng_e;

  logic              frame_vld;
  frame_t            frame;
  kind_e             kind_in, kind_q;
  eng_e              state_q;
  logic              sel_q, rw_q, dp_oe_q, wclk0_q, wclk1_q;
  logic [DATA_W-1:0] dp_q;
  logic [CTL_W-1:0]  ctl_q;
  logic              accept, tmr_load, tmr_zero, tx_start, tx_last;
  logic [TW-1:0]     tmr_val;
  int unsigned       low_w;

  dls_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_en(rx_en),
    .frame_vld(frame_vld), .frame(frame)
  );

  assign kind_in  = classify(frame.lng, frame.rw, spi_mode);
  assign accept   = frame_vld && (state_q == E_IDLE) && (kind_in != K_NONE);
  assign low_w    = low_cycles(kind_q, sel_q, LOW_W0, LOW_W1, LOW_RD, LOW_SPI);
  assign tmr_load = accept || (state_q == E_SETUP && tmr_zero);
  assign tmr_val  = accept ? TW'(SETUP_CYC - 1) : TW'(low_w - 1);
  assign tx_start = (state_q == E_LOW) && tmr_zero && (kind_q == K_READ);

  dls_down_timer #(.MAXV(MAXW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  // the display's bus is sampled on the edge where the read strobe rises
  dls_ret_tx u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .data(dp_in),
    .tx_bit(tx_bit), .tx_en(tx_en), .last(tx_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= E_IDLE;
      kind_q  <= K_NONE;
      sel_q   <= 1'b0;
      rw_q    <= 1'b0;
      dp_q    <= '0;
      dp_oe_q <= 1'b1;
      ctl_q   <= '0;
      wclk0_q <= 1'b1;
      wclk1_q <= 1'b1;
    end else begin
      case (state_q)
        E_IDLE: if (accept) begin
          kind_q  <= kind_in;
          sel_q   <= frame.sel;
          rw_q    <= frame.rw;
          wclk1_q <= 1'b1;
          state_q <= E_SETUP;
          case (kind_in)
            K_WRITE: begin
              dp_q    <= frame.data;
              dp_oe_q <= 1'b1;
              ctl_q   <= frame.ctl;
              wclk0_q <= 1'b1;
            end
            K_READ: begin
              dp_oe_q <= 1'b0;
              ctl_q   <= frame.ctl;
              wclk0_q <= 1'b1;
            end
            default: begin
              dp_oe_q                <= 1'b1;
              dp_q[SPI_DP_DAT]       <= frame.ctl[SPI_CT_DAT];
              dp_q[SPI_DP_CLK]       <= 1'b1;
              ctl_q                  <= frame.ctl;
              ctl_q[SPI_CT_CLK]      <= 1'b1;
              wclk0_q                <= frame.ctl[SPI_CT_CS];
            end
          endcase
        end
        E_SETUP: if (tmr_zero) begin
          state_q <= E_LOW;
          if (kind_q == K_SPI) begin
            dp_q[SPI_DP_CLK]  <= 1'b0;
            ctl_q[SPI_CT_CLK] <= 1'b0;
          end else if (sel_q) wclk1_q <= 1'b0;
          else                wclk0_q <= 1'b0;
        end
        E_LOW: if (tmr_zero) begin
          state_q <= (kind_q == K_READ) ? E_TX : E_IDLE;
          if (kind_q == K_SPI) begin
            dp_q[SPI_DP_CLK]  <= 1'b1;
            ctl_q[SPI_CT_CLK] <= 1'b1;
          end else if (sel_q) wclk1_q <= 1'b1;
          else                wclk0_q <= 1'b1;
        end
        default: if (tx_last) state_q <= E_IDLE;
      endcase
    end
  end

  assign dp_out  = dp_q;
  assign dp_oe   = dp_oe_q;
  assign ctl_out = ctl_q;
  assign rw_out  = rw_q;
  assign wclk0   = wclk0_q;
  assign wclk1   = wclk1_q;

  // R10: the two write clocks are never low together
  p_single_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wclk0 && !wclk1));
  // R4: the bus stays released for the whole read strobe
  p_bus_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == E_LOW && kind_q == K_READ) |-> !dp_oe);
  // R3: port values hold while a strobe is low
  p_hold_while_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == E_LOW && $past(state_q) == E_LOW) |->
      ($stable(dp_out) && $stable(ctl_out) && $stable(rw_out)));
  // R3: write clock 1 only falls after the setup phase
  p_setup_before_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wclk1) |-> ($past(state_q) == E_SETUP));
  // R2: write clock 1 rests high whenever the engine is idle
  p_idle_wclk1_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == E_IDLE) |-> wclk1);
endmodule

// File: tb/tb_disp_link_slave.sv
module tb_disp_link_slave;
  localparam int S = 2, W0 = 15, W1 = 6, WR = 56, WS = 12;

  logic        clk = 1'b0, rst_n = 1'b0, spi_mode = 1'b0, rx_bit = 1'b0, rx_en = 1'b0;
  logic [17:0] dp_in = '0, dp_out, rd_val = '0;
  logic [5:0]  ctl_out;
  logic        dp_oe, rw_out, wclk0, wclk1, tx_bit, tx_en;

  int n_chk = 0, n_bad = 0;
  logic [17:0] pre_dp, snap_dp;
  logic [5:0]  pre_ctl, snap_ctl;
  logic        snap_rw, snap_oe, snap_w0;
  bit          other_low, unstable;

  always #4 clk = ~clk;

  disp_link_slave dut (
    .clk(clk), .rst_n(rst_n), .spi_mode(spi_mode), .rx_bit(rx_bit), .rx_en(rx_en),
    .dp_in(dp_in), .dp_out(dp_out), .dp_oe(dp_oe), .ctl_out(ctl_out), .rw_out(rw_out),
    .wclk0(wclk0), .wclk1(wclk1), .tx_bit(tx_bit), .tx_en(tx_en)
  );

  // display model: answers a read while any write clock is low
  always @(negedge clk) dp_in <= (!wclk0 || !wclk1) ? rd_val : ~rd_val;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input bit lng, input bit sel, input bit rw, input logic [5:0] ctl,
                      input logic [17:0] data);
    rx_en = 1'b1; rx_bit = lng; @(negedge clk);
    if (lng) for (int i = 0; i < 18; i++) begin rx_bit = data[i]; @(negedge clk); end
    for (int i = 0; i < 6; i++) begin rx_bit = ctl[i]; @(negedge clk); end
    rx_bit = rw;  @(negedge clk);
    rx_bit = sel; @(negedge clk);
    rx_en = 1'b0; rx_bit = 1'b0;
  endtask

  function automatic logic sig_of(input int which);
    case (which)
      0:       return wclk0;
      1:       return wclk1;
      default: return ctl_out[5];
    endcase
  endfunction

  task automatic measure(input int which, input int tmo, output int width);
    int t;
    width = 0; t = 0; other_low = 0; unstable = 0;
    while (sig_of(which) !== 1'b1 && t < tmo) begin @(negedge clk); t++; end
    while (sig_of(which) !== 1'b0 && t < tmo) begin
      pre_dp = dp_out; pre_ctl = ctl_out; @(negedge clk); t++;
    end
    if (sig_of(which) !== 1'b0) return;
    snap_dp = dp_out; snap_ctl = ctl_out; snap_rw = rw_out; snap_oe = dp_oe; snap_w0 = wclk0;
    while (sig_of(which) === 1'b0 && width < 1000) begin
      width++;
      if ((which == 1) ? !wclk0 : !wclk1) other_low = 1;
      if (dp_out !== snap_dp || ctl_out !== snap_ctl) unstable = 1;
      @(negedge clk);
    end
  endtask

  task automatic get_ret(output logic [17:0] d, output bit ok);
    int t;
    t = 0; ok = 1; d = '0;
    while (!tx_en && t < 300) begin @(negedge clk); t++; end
    if (!tx_en) begin ok = 0; return; end
    for (int i = 0; i < 27; i++) begin
      if (!tx_en) ok = 0;
      if (i == 0) begin if (tx_bit !== 1'b1) ok = 0; end
      else if (i <= 18) d[i-1] = tx_bit;
      else if (tx_bit !== 1'b0) ok = 0;
      @(negedge clk);
    end
    if (tx_en) ok = 0;
  endtask

  function automatic logic [17:0] pat(input int p);
    if (p < 6)       return 18'h1 << (p * 3);
    else if (p == 6) return 18'h2AAAA;
    else             return 18'h15555;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int w;
    logic [17:0] d;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9", "wclk0", wclk0, 1);
    chk("R9", "wclk1", wclk1, 1);
    chk("R9", "dp_out", dp_out, 0);
    chk("R9", "ctl_out", ctl_out, 0);
    chk("R9", "rw_out", rw_out, 0);
    chk("R9", "dp_oe", dp_oe, 1);
    chk("R9", "tx_en", tx_en, 0);

    // R1/R2/R3 write sweep over both write clocks and 8 data patterns
    for (int sel = 0; sel < 2; sel++)
      for (int p = 0; p < 8; p++) begin
        logic [17:0] dv;
        logic [5:0]  cv;
        dv = pat(p) ^ (sel ? 18'h3F000 : 18'h0);
        cv = 6'(p * 11 + sel * 5);
        fork
          send(1'b1, sel[0], 1'b0, cv, dv);
          measure(sel, 300, w);
        join
        chk("R2", "write low width", w, sel ? W1 : W0);
        chk("R1", "write data", snap_dp, dv);
        chk("R1", "write ctl", snap_ctl, cv);
        chk("R3", "data set before fall", pre_dp, dv);
        chk("R3", "ctl set before fall", pre_ctl, cv);
        chk("R3", "stable while low", unstable, 0);
        chk("R2", "rw/oe during write", {snap_rw, snap_oe}, 2'b01);
        chk("R10", "other clock low", other_low, 0);
        repeat (4) @(negedge clk);
      end

    // R4/R5 reads on both clocks
    for (int sel = 0; sel < 2; sel++)
      for (int p = 0; p < 3; p++) begin
        logic [5:0] cv;
        rd_val = pat(p * 2 + sel) ^ 18'h24924;
        cv = 6'(p * 13 + 7 + sel);
        fork
          send(1'b0, sel[0], 1'b1, cv, '0);
          measure(sel, 300, w);
        join
        get_ret(d, ok);
        chk("R4", "read low width", w, WR);
        chk("R4", "bus released", snap_oe, 0);
        chk("R4", "read ctl/rw", {snap_ctl, snap_rw}, {cv, 1'b1});
        chk("R10", "other clock low on read", other_low, 0);
        chk("R5", "return frame shape", ok, 1);
        chk("R5", "returned data", d, rd_val);
        repeat (4) @(negedge clk);
      end

    // R6 serial-peripheral writes: all chip-select / data combinations
    spi_mode = 1'b1;
    for (int c = 0; c < 4; c++) begin
      logic [5:0] cv;
      cv = {c[1], c[0], 4'(c * 5 + 3)};
      fork
        send(1'b0, 1'b0, 1'b0, cv, '0);
        measure(2, 300, w);
      join
      chk("R6", "sclk low width", w, WS);
      chk("R6", "chip select on wclk0", snap_w0, c[1]);
      chk("R6", "data on dp7/ctl4", {snap_dp[7], snap_ctl[4]}, {c[0], c[0]});
      chk("R6", "ctl low bits", snap_ctl[3:0], cv[3:0]);
      chk("R6", "sclk on dp6", snap_dp[6], 0);
      chk("R6", "wclk1 high", other_low, 0);
      chk("R6", "sclk returns high", {dp_out[6], ctl_out[5]}, 2'b11);
      repeat (4) @(negedge clk);
    end
    spi_mode = 1'b0;

    // R7 ignored short write frame outside SPI mode
    fork
      send(1'b1, 1'b1, 1'b0, 6'h2D, 18'h1E0F3);
      measure(1, 300, w);
    join
    repeat (4) @(negedge clk);
    fork
      send(1'b0, 1'b1, 1'b0, 6'h12, '0);
      measure(1, 60, w);
    join
    chk("R7", "no strobe", w, 0);
    chk("R7", "outputs kept", {dp_out, ctl_out, rw_out, dp_oe, wclk0, wclk1},
        {18'h1E0F3, 6'h2D, 1'b0, 1'b1, 1'b1, 1'b1});

    // R8 frame ending on the strobe's rising edge: accepted
    rd_val = 18'h3A5C1;
    fork
      begin
        send(1'b1, 1'b0, 1'b0, 6'h01, 18'h00F0F);
        repeat (1 + S + W0 - 9) @(negedge clk);
        send(1'b0, 1'b1, 1'b1, 6'h22, '0);
      end
      measure(0, 300, w);
    join
    chk("R8", "first write width", w, W0);
    measure(1, 200, w);
    get_ret(d, ok);
    chk("R8", "late frame accepted", w, WR);
    chk("R8", "late frame data", {ok, d}, {1'b1, rd_val});
    repeat (4) @(negedge clk);

    // R8 frame ending one cycle earlier: dropped
    fork
      begin
        send(1'b1, 1'b0, 1'b0, 6'h03, 18'h0A0A0);
        repeat (S + W0 - 9) @(negedge clk);
        send(1'b0, 1'b1, 1'b1, 6'h22, '0);
      end
      measure(0, 300, w);
    join
    chk("R8", "write width before drop", w, W0);
    measure(1, 120, w);
    chk("R8", "early frame dropped", w, 0);
    chk("R8", "bus still driven", {dp_oe, tx_en, dp_out}, {1'b1, 1'b0, 18'h0A0A0});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule